// File: doc/BRIEF.md
# Training-Word Lane Deserializer

This block turns a group of serial lanes into parallel words of a fixed width of 4, 7 or 8 bits. It runs on the bit-rate clock. A frame strobe, high for one bit period, marks the word boundary that the rest of the chip expects. Each lane may be skewed by a whole number of bit periods against that boundary. Calibration learns each lane's skew on its own, so that every lane delivers the same word together.

While the calibrate input is held high, each lane receives a known training word over and over. For each frame, every lane checks all possible bit rotations against that word. The first rotation that matches on three frames in a row is locked in, and the lane's locked flag rises. When calibrate falls, the learned rotations stay frozen. Every lane then delivers its word at that rotation on every frame strobe. If any lane has not locked when calibrate falls, a sticky error flag is raised. The next calibration clears it.

Top module: `trainword_deser`

## Requirements
- R1: The training word has its lower half (integer half of the width) set to one and the rest zero: 0011 for width 4, 0000111 for width 7, 00001111 for width 8. The first bit received is the word's MSB.
- R2: During calibration, a lane locks after its training word is seen at one rotation on three counted frame strobes in a row. A strobe counts when calibrate is high in that cycle and in the cycle before. The lane's locked flag is high from the cycle after the edge that samples the third matching strobe.
- R3: Each lane learns its own rotation, from 0 to width-1 bit periods. Rotation r selects the word whose last bit arrived r bit periods before the frame strobe, so lanes with different skews all deliver the same transmitted word.
- R4: The rotation is frozen while a lane stays locked. On every frame strobe, each lane captures the word at its current rotation. Lane n drives par_out bits [n*W+W-1 : n*W], with the earliest-received bit in the top position.
- R5: A locked flag stays high through the rest of the calibration and after it ends. A rising edge of calibrate clears every locked flag by the next cycle.
- R6: cal_error is set in the cycle after calibrate falls if any lane is not locked. It is cleared in the cycle after calibrate rises, and otherwise holds its value.
- R7: word_valid pulses for one cycle, 1 + OUTPUT_REG cycles after each sampled frame strobe, together with the words captured at that strobe. The bus is held between strobes.
- R8: After reset, par_out, word_valid, lane_locked and cal_error are all zero.
- R9: A frame that does not match breaks a lane's run of matches. A lane whose training word is corrupted in one frame out of four counted frames stays unlocked, while the other lanes lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | NUM_LANES | One serial bit per lane per clock |
| cal_req | input | 1 | Calibration request, level sensitive |
| frame_tick | input | 1 | One-cycle frame boundary strobe |
| par_out | output | NUM_LANES*WORD_W | Packed parallel words, lane 0 in the low bits |
| word_valid | output | 1 | New words present on par_out |
| lane_locked | output | NUM_LANES | Per-lane alignment locked flag |
| cal_error | output | 1 | Sticky: a calibration ended with an unlocked lane |

## Verification
A strobe sampled at edge k makes word_valid and the new words visible after edge k+1+OUTPUT_REG. Locked flags and cal_error change after the same edge that samples their cause: the third matching strobe, or the calibrate edge. The bench drives inputs on the falling edge and keeps a behavioural model that it advances on each rising edge. It compares every output on the next falling edge, so each result is checked in the cycle in which it is due. Directed checks also recover the transmitted data word from the frame index of each valid pulse, with lanes running at several different skews.

// File: rtl/trd_pkg.sv
`timescale 1ns/1ps
package trd_pkg;

    localparam int MAX_WORD = 8;

    typedef enum logic [1:0] {
        CAL_IDLE,
        CAL_ENTER,
        CAL_HUNT,
        CAL_LEAVE
    } cal_phase_e;

    // Training word: the low half (integer half) of the bits set.
    function automatic logic [MAX_WORD-1:0] train_pattern(input int width);
        logic [MAX_WORD-1:0] p;
        p = '0;
        for (int b = 0; b < MAX_WORD; b++) begin
            if (b < width / 2) p[b] = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/trd_lane_align.sv
`timescale 1ns/1ps
module trd_lane_align
    import trd_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int HIT_NEED = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_i,
    input  logic              tick_i,
    input  logic              cal_run_i,
    input  logic              cal_start_i,
    output logic [WORD_W-1:0] word_o,
    output logic              locked_o
);

    localparam int HIST_W = 2 * WORD_W;
    localparam int OFF_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int CNT_W  = $clog2(HIT_NEED + 1);
    localparam logic [WORD_W-1:0] TRAIN = WORD_W'(train_pattern(WORD_W));

    typedef struct packed {
        logic [HIST_W-1:0]             hist;
        logic [WORD_W-1:0][CNT_W-1:0]  hits;
        logic                          locked;
        logic [OFF_W-1:0]              offset;
        logic [WORD_W-1:0]             word;
    } lane_st_t;

    lane_st_t          st_q, st_d;
    logic [WORD_W-1:0] win [WORD_W];
    logic [WORD_W-1:0] match;
    logic              found;
    logic [OFF_W-1:0]  pick;

    always_comb begin
        st_d      = st_q;
        found     = 1'b0;
        pick      = '0;
        // newest bit enters at position 0
        st_d.hist = {st_q.hist[HIST_W-2:0], ser_i};

        for (int r = 0; r < WORD_W; r++) begin
            win[r]   = st_d.hist[r +: WORD_W];
            match[r] = (win[r] == TRAIN);
        end

        // capture at the current (old) rotation on every frame strobe
        if (tick_i) begin
            for (int r = 0; r < WORD_W; r++) begin
                if (st_q.offset == OFF_W'(r)) st_d.word = win[r];
            end
        end

        if (cal_start_i) begin
            st_d.locked = 1'b0;
            st_d.hits   = '0;
        end else if (cal_run_i && tick_i && !st_q.locked) begin
            for (int r = 0; r < WORD_W; r++) begin
                if (!match[r])
                    st_d.hits[r] = '0;
                else if (st_q.hits[r] != CNT_W'(HIT_NEED))
                    st_d.hits[r] = st_q.hits[r] + CNT_W'(1);
            end
            // lowest rotation wins when several reach the run length
            for (int r = WORD_W - 1; r >= 0; r--) begin
                if (st_d.hits[r] == CNT_W'(HIT_NEED)) begin
                    found = 1'b1;
                    pick  = OFF_W'(r);
                end
            end
            if (found) begin
                st_d.locked = 1'b1;
                st_d.offset = pick;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o   = st_q.word;
    assign locked_o = st_q.locked;

    // R5: lock persists until a new calibration starts
    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && !cal_start_i) |=> st_q.locked);

    // R4: rotation frozen while locked
    assert_offset_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && !cal_start_i) |=> $stable(st_q.offset));

    // R2: lock only follows a counted frame strobe
    assert_lock_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> $past(tick_i && cal_run_i));

    // R7: captured word changes only after a strobe
    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.word));

endmodule

// File: rtl/trd_out_stage.sv
`timescale 1ns/1ps
module trd_out_stage #(
    parameter int DATA_W  = 32,
    parameter bit USE_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    generate
        if (USE_REG) begin : g_reg
            typedef struct packed {
                logic [DATA_W-1:0] data;
                logic              valid;
            } out_st_t;

            out_st_t st_q, st_d;

            always_comb begin
                st_d.data  = data_i;
                st_d.valid = valid_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign data_o  = st_q.data;
            assign valid_o = st_q.valid;
        end else begin : g_pass
            assign data_o  = data_i;
            assign valid_o = valid_i;
        end
    endgenerate

endmodule

// File: rtl/trainword_deser.sv
`timescale 1ns/1ps
module trainword_deser
    import trd_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int WORD_W     = 8,
    parameter int HIT_NEED   = 3,
    parameter bit OUTPUT_REG = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES-1:0]        ser_in,
    input  logic                        cal_req,
    input  logic                        frame_tick,
    output logic [NUM_LANES*WORD_W-1:0] par_out,
    output logic                        word_valid,
    output logic [NUM_LANES-1:0]        lane_locked,
    output logic                        cal_error
);

    localparam int BUS_W = NUM_LANES * WORD_W;
    localparam int VLAT  = 1 + int'(OUTPUT_REG);

    typedef struct packed {
        logic cal_prev;
        logic tick_seen;
        logic err;
    } top_st_t;

    top_st_t            st_q, st_d;
    cal_phase_e         phase;
    logic [BUS_W-1:0]   word_bus;
    logic [NUM_LANES-1:0] locked_w;

    always_comb begin
        st_d = st_q;
        unique case ({cal_req, st_q.cal_prev})
            2'b10:   phase = CAL_ENTER;
            2'b11:   phase = CAL_HUNT;
            2'b01:   phase = CAL_LEAVE;
            default: phase = CAL_IDLE;
        endcase

        st_d.cal_prev  = cal_req;
        st_d.tick_seen = frame_tick;

        unique case (phase)
            CAL_ENTER: st_d.err = 1'b0;
            CAL_LEAVE: if (!(&locked_w)) st_d.err = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        trd_lane_align #(
            .WORD_W   (WORD_W),
            .HIT_NEED (HIT_NEED)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .ser_i       (ser_in[g]),
            .tick_i      (frame_tick),
            .cal_run_i   (phase == CAL_HUNT),
            .cal_start_i (phase == CAL_ENTER),
            .word_o      (word_bus[g*WORD_W +: WORD_W]),
            .locked_o    (locked_w[g])
        );
    end

    trd_out_stage #(
        .DATA_W  (BUS_W),
        .USE_REG (OUTPUT_REG)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_i  (word_bus),
        .valid_i (st_q.tick_seen),
        .data_o  (par_out),
        .valid_o (word_valid)
    );

    assign lane_locked = locked_w;
    assign cal_error   = st_q.err;

    // R5: a new calibration clears every lock
    assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_req) |=> (lane_locked == '0));

    // R6: error clears when calibration restarts
    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_req) |=> !cal_error);

    // R6: error is raised only once calibrate is low
    assert_err_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_error) |-> $past(!cal_req));

    // R7: valid follows a strobe by the pipeline latency
    assert_valid_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(frame_tick, VLAT));

endmodule

// File: tb/trainword_deser_tb.sv
`timescale 1ns/1ps
module trainword_deser_tb;

    localparam int LANES = 4;
    localparam int W     = 8;
    localparam int NEED  = 3;
    localparam bit OREG  = 1'b1;
    localparam int BUS   = LANES * W;
    localparam logic [W-1:0] TRAIN = 8'b0000_1111;   // R1

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LANES-1:0] ser = '0;
    logic             cal = 1'b0;
    logic             tick = 1'b0;
    logic [BUS-1:0]   par_out;
    logic             word_valid;
    logic [LANES-1:0] lane_locked;
    logic             cal_error;

    trainword_deser #(
        .NUM_LANES (LANES),
        .WORD_W    (W),
        .HIT_NEED  (NEED),
        .OUTPUT_REG(OREG)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser),
        .cal_req    (cal),
        .frame_tick (tick),
        .par_out    (par_out),
        .word_valid (word_valid),
        .lane_locked(lane_locked),
        .cal_error  (cal_error)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cyc    = 0;
    int skew [LANES];
    int train_until = 1000000;
    int bad_lane = -1;
    int bad_word = -1;

    // ---------------- stimulus ----------------
    function automatic logic [W-1:0] data_word(input int l, input int j);
        return W'((j * 37 + l * 11 + 5) ^ (j >> 1));
    endfunction

    function automatic logic [W-1:0] tx_word(input int l, input int j);
        if (l == bad_lane && j == bad_word) return ~TRAIN;
        if (j < train_until) return TRAIN;
        return data_word(l, j);
    endfunction

    function automatic logic tx_bit(input int l, input int c);
        int idx;
        logic [W-1:0] w;
        idx = c + skew[l];
        w   = tx_word(l, idx / W);
        return w[W-1 - (idx % W)];
    endfunction

    // ---------------- reference model ----------------
    typedef bit bitq_t[$];
    bitq_t            mh [LANES];
    int               m_cnt [LANES][W];
    int               m_off [LANES];
    logic [W-1:0]     m_w1 [LANES];
    logic             m_v1;
    logic [BUS-1:0]   m_out;
    logic             m_vout;
    logic [LANES-1:0] m_lock;
    logic             m_err;
    logic             m_calp;

    function automatic logic [W-1:0] m_win(input int l, input int r);
        logic [W-1:0] v;
        for (int b = 0; b < W; b++) v[b] = mh[l][r + b];
        return v;
    endfunction

    function automatic logic [BUS-1:0] m_pack();
        logic [BUS-1:0] p;
        for (int l = 0; l < LANES; l++) p[l*W +: W] = m_w1[l];
        return p;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LANES; l++) begin
                mh[l].delete();
                for (int b = 0; b < 2 * W; b++) mh[l].push_back(1'b0);
                for (int r = 0; r < W; r++) m_cnt[l][r] = 0;
                m_off[l] = 0;
                m_w1[l]  = '0;
            end
            m_v1 = 0; m_out = '0; m_vout = 0; m_lock = '0; m_err = 0; m_calp = 0;
        end else begin
            if (OREG) begin
                m_out  = m_pack();
                m_vout = m_v1;
            end
            m_v1 = tick;
            for (int l = 0; l < LANES; l++) begin
                mh[l].push_front(ser[l]);
                void'(mh[l].pop_back());
            end
            if (tick)
                for (int l = 0; l < LANES; l++) m_w1[l] = m_win(l, m_off[l]);
            if (!OREG) begin
                m_out  = m_pack();
                m_vout = m_v1;
            end
            if (cal && !m_calp) begin
                m_err  = 0;
                m_lock = '0;
                for (int l = 0; l < LANES; l++)
                    for (int r = 0; r < W; r++) m_cnt[l][r] = 0;
            end else begin
                if (!cal && m_calp && m_lock != '1) m_err = 1;
                if (cal && m_calp && tick) begin
                    for (int l = 0; l < LANES; l++) begin
                        if (!m_lock[l]) begin
                            for (int r = 0; r < W; r++)
                                m_cnt[l][r] = (m_win(l, r) == TRAIN) ?
                                              ((m_cnt[l][r] < NEED) ? m_cnt[l][r] + 1 : NEED) : 0;
                            for (int r = W - 1; r >= 0; r--)
                                if (m_cnt[l][r] == NEED) begin
                                    m_lock[l] = 1'b1;
                                    m_off[l]  = r;
                                end
                        end
                    end
                end
            end
            m_calp = cal;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        if (!rst_n) return;
        chk(par_out === m_out, "R4 par_out", 64'(par_out), 64'(m_out));
        chk(word_valid === m_vout, "R7 word_valid", 64'(word_valid), 64'(m_vout));
        chk(lane_locked === m_lock, "R2 lane_locked", 64'(lane_locked), 64'(m_lock));
        chk(cal_error === m_err, "R6 cal_error", 64'(cal_error), 64'(m_err));
    endtask

    task automatic drive();
        tick = ((cyc % W) == W - 1);
        for (int l = 0; l < LANES; l++) ser[l] = tx_bit(l, cyc);
        cyc++;
    endtask

    task automatic step_with(input logic cal_next);
        @(negedge clk);
        compare_all();
        cal = cal_next;
        drive();
    endtask

    task automatic step();
        step_with(cal);
    endtask

    task automatic calibrate(input int nticks, input int bad_l, input logic [LANES-1:0] exp_mask);
        int n;
        while ((cyc % W) != 2) step();
        bad_lane = bad_l;
        bad_word = cyc / W + 1;          // second counted frame
        step_with(1'b1);
        step();
        chk(lane_locked == '0, "R5 cleared on calibrate rise", 64'(lane_locked), 64'(0));
        chk(cal_error == 1'b0, "R6 cleared on calibrate rise", 64'(cal_error), 64'(0));
        n = 0;
        while (n < nticks) begin
            step();
            if (tick) n++;
        end
        step();
        chk(lane_locked == exp_mask, (bad_l >= 0) ? "R9 broken run" : "R1 R2 lock",
            64'(lane_locked), 64'(exp_mask));
        step_with(1'b0);
        step();
        chk(lane_locked == exp_mask, "R5 lock kept after calibrate falls",
            64'(lane_locked), 64'(exp_mask));
        chk(cal_error == (exp_mask != '1), "R6 error at calibrate fall",
            64'(cal_error), 64'(exp_mask != '1));
        bad_lane = -1;
    endtask

    task automatic data_phase(input int frames);
        int c;
        int j;
        train_until = cyc / W + 2;
        repeat (frames * W) begin
            step();
            if (word_valid) begin
                c = cyc - 2 - int'(OREG);
                j = c / W;
                if (j > train_until)
                    for (int l = 0; l < LANES; l++)
                        chk(par_out[l*W +: W] == data_word(l, j), "R3 lane word after alignment",
                            64'(par_out[l*W +: W]), 64'(data_word(l, j)));
            end
        end
    endtask

    initial begin
        skew = '{0, 2, 5, 7};
        repeat (3) @(negedge clk);
        chk(par_out == '0, "R8 reset par_out", 64'(par_out), 64'(0));
        chk(word_valid == 1'b0, "R8 reset word_valid", 64'(word_valid), 64'(0));
        chk(lane_locked == '0, "R8 reset lane_locked", 64'(lane_locked), 64'(0));
        chk(cal_error == 1'b0, "R8 reset cal_error", 64'(cal_error), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        drive();
        repeat (3 * W) step();

        calibrate(5, -1, '1);
        data_phase(6);

        train_until = 1000000;
        repeat (3 * W) step();
        calibrate(4, 1, 4'b1101);

        skew = '{3, 1, 6, 0};
        repeat (3 * W) step();
        calibrate(3, -1, '1);
        data_phase(6);

        repeat (4) step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog R2 run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule